// File: doc/BRIEF.md
# Speculative Reorder Buffer with In-Order Retirement

This block holds in-flight instructions of a speculative out-of-order core between issue and retirement. Each instruction takes one slot of a circular buffer, in program order, when it issues. The slot index goes back to the issue stage as the tag under which the instruction's result will later be broadcast. Each slot records the instruction kind, its destination, its result value, a ready flag, a mispredict flag and a fault flag. A destination is a register number for register operations and a memory address for stores. Branches have no destination.

Execution units broadcast results on a common data bus (CDB) port, addressed by tag. The oldest slot, the head, retires once its result is present. A register operation then produces a register-file write. A store produces its memory write at this point and not earlier. A branch that was predicted correctly simply leaves the buffer. A mispredicted branch, or any entry whose fault flag is set, causes a flush when it reaches the head. The flush empties the whole buffer in one cycle. A faulting entry also raises an exception and makes no write.

Occupancy is tracked by a three-state machine. The states are OCC_EMPTY, OCC_MID and OCC_FULL, and the full and empty outputs are decoded from the state. The transitions are as follows:
- fill-start: OCC_EMPTY to OCC_MID, on an allocation.
- fill-top: OCC_MID to OCC_FULL, on an allocation without a retirement while one slot is free.
- drain-last: OCC_MID to OCC_EMPTY, on a retirement without an allocation while one entry is held.
- drain-one: OCC_FULL to OCC_MID, on a retirement.
- squash: any state to OCC_EMPTY, on a flush.

Each cycle the retirement logic picks one action for the head: RET_WAIT, RET_REG, RET_STORE, RET_BRANCH, RET_REDIRECT or RET_FAULT.

Top module: `rob_core`

## Requirements
- R1: After reset, empty is 1, full is 0, occ is 0, cmt_valid is 0 and iss_tag is 0.
- R2: When iss_valid is high and full is low (and no flush is in progress), an entry is allocated at the slot given by iss_tag. iss_tag then advances by one, modulo DEPTH. While full is high, an issue request is ignored and iss_tag and occ do not change. The kind encoding is 2'b00 branch, 2'b01 store, 2'b10 register operation.
- R3: occ counts the entries held. empty is 1 exactly when occ is 0, and full is 1 exactly when occ equals DEPTH.
- R4: A CDB broadcast stores the value, mispredict bit and fault bit into the tagged entry and marks it ready, but only if that entry is allocated. A broadcast to an unallocated slot has no effect, even on an entry later allocated in that slot.
- R5: Only the head entry retires, and only once it is ready, so retirement follows program order. cmt_valid is high during the cycle the head is ready and the entry leaves at the next clock edge.
- R6: A retiring register operation drives reg_wr_en with reg_wr_idx equal to the low REG_W bits of its destination and reg_wr_data equal to its value.
- R7: A store drives mem_wr_en, with mem_wr_addr equal to its destination and mem_wr_data equal to its value, only in its retirement cycle.
- R8: A retiring branch with the mispredict bit set drives flush. One cycle later the buffer is empty, iss_tag is 0, and none of the younger entries ever retires. A correctly predicted branch retires with no write and no flush.
- R9: A retiring entry with the fault bit set drives exc_raise and flush, makes neither a register nor a memory write, and leaves the buffer empty one cycle later.
- R10: An allocation and a retirement in the same cycle leave occ unchanged.
- R11: An issue request during a flush cycle is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid | input | 1 | Issue request |
| iss_kind | input | 2 | Kind of issuing instruction |
| iss_dest | input | DEST_W | Register number or store address |
| iss_tag | output | TAG_W | Slot an issue would take |
| full | output | 1 | No free slot |
| empty | output | 1 | No entry held |
| occ | output | CNT_W | Number of entries held |
| cdb_valid | input | 1 | Result broadcast valid |
| cdb_tag | input | TAG_W | Tag of broadcast result |
| cdb_value | input | DATA_W | Result value |
| cdb_mispred | input | 1 | Branch outcome differs from prediction |
| cdb_fault | input | 1 | Instruction faulted |
| cmt_valid | output | 1 | Head retires this cycle |
| cmt_kind | output | 2 | Kind of retiring entry |
| reg_wr_en | output | 1 | Register write |
| reg_wr_idx | output | REG_W | Register number |
| reg_wr_data | output | DATA_W | Register data |
| mem_wr_en | output | 1 | Store write to memory |
| mem_wr_addr | output | DEST_W | Store address |
| mem_wr_data | output | DATA_W | Store data |
| flush | output | 1 | Squash every entry |
| exc_raise | output | 1 | Exception at retirement |

## Verification
The bench builds the block with DEPTH=4, DEST_W=12, DATA_W=16 and REG_W=4. The shallow buffer makes the full state, the blocked issue and pointer wraparound reachable within a few dozen cycles. A register width narrower than the destination field tests that only the low bits of the destination reach reg_wr_idx. Results are returned out of order, and a flush is taken while younger ready entries sit behind the head. A stale broadcast to an emptied slot is also exercised.

// File: rtl/rob_pkg.sv
package rob_pkg;

    typedef enum logic [1:0] {
        KIND_BRANCH = 2'b00,
        KIND_STORE  = 2'b01,
        KIND_REG    = 2'b10
    } op_kind_e;

    typedef enum logic [1:0] {
        OCC_EMPTY,
        OCC_MID,
        OCC_FULL
    } occ_state_e;

    typedef enum logic [2:0] {
        RET_WAIT,
        RET_REG,
        RET_STORE,
        RET_BRANCH,
        RET_REDIRECT,
        RET_FAULT
    } ret_action_e;

endpackage

// File: rtl/rob_ptrs.sv
module rob_ptrs
    import rob_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int TAG_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alloc_req,
    input  logic             retire,
    input  logic             flush,
    output logic             alloc_ok,
    output logic [TAG_W-1:0] head_q,
    output logic [TAG_W-1:0] tail_q,
    output logic [CNT_W-1:0] occ_q,
    output logic             full,
    output logic             empty
);

    localparam logic [TAG_W-1:0] LAST_IDX = TAG_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] ONE_LEFT = CNT_W'(DEPTH - 1);

    occ_state_e st_q, st_d;

    function automatic logic [TAG_W-1:0] bump(input logic [TAG_W-1:0] p);
        return (p == LAST_IDX) ? '0 : p + 1'b1;
    endfunction

    assign alloc_ok = alloc_req && (st_q != OCC_FULL) && !flush;

    // next-state selection
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            OCC_EMPTY: begin
                if (alloc_ok) st_d = OCC_MID;
            end
            OCC_MID: begin
                if (flush)
                    st_d = OCC_EMPTY;
                else if (alloc_ok && !retire && occ_q == ONE_LEFT)
                    st_d = OCC_FULL;
                else if (retire && !alloc_ok && occ_q == CNT_W'(1))
                    st_d = OCC_EMPTY;
            end
            OCC_FULL: begin
                if (flush)       st_d = OCC_EMPTY;
                else if (retire) st_d = OCC_MID;
            end
            default: st_d = OCC_EMPTY;
        endcase
    end

    // state and pointer registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= OCC_EMPTY;
            head_q <= '0;
            tail_q <= '0;
            occ_q  <= '0;
        end else if (flush) begin
            st_q   <= OCC_EMPTY;
            head_q <= '0;
            tail_q <= '0;
            occ_q  <= '0;
        end else begin
            st_q <= st_d;
            if (retire)   head_q <= bump(head_q);
            if (alloc_ok) tail_q <= bump(tail_q);
            unique case ({alloc_ok, retire})
                2'b10:   occ_q <= occ_q + 1'b1;
                2'b01:   occ_q <= occ_q - 1'b1;
                default: occ_q <= occ_q;
            endcase
        end
    end

    // outputs decoded from state
    always_comb begin
        full  = (st_q == OCC_FULL);
        empty = (st_q == OCC_EMPTY);
    end

endmodule

// File: rtl/rob_slots.sv
module rob_slots #(
    parameter int DEPTH  = 8,
    parameter int DEST_W = 32,
    parameter int DATA_W = 32,
    localparam int TAG_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              alloc_ok,
    input  logic [TAG_W-1:0]  tail,
    input  logic [1:0]        alloc_kind,
    input  logic [DEST_W-1:0] alloc_dest,
    input  logic              retire,
    input  logic [TAG_W-1:0]  head,
    input  logic              cdb_valid,
    input  logic [TAG_W-1:0]  cdb_tag,
    input  logic [DATA_W-1:0] cdb_value,
    input  logic              cdb_mispred,
    input  logic              cdb_fault,
    output logic              head_valid,
    output logic              head_ready,
    output logic [1:0]        head_kind,
    output logic [DEST_W-1:0] head_dest,
    output logic [DATA_W-1:0] head_value,
    output logic              head_mp,
    output logic              head_fault
);

    logic [DEPTH-1:0]  valid_vec, ready_vec, mp_vec, fault_vec;
    logic [1:0]        kind_arr  [DEPTH];
    logic [DEST_W-1:0] dest_arr  [DEPTH];
    logic [DATA_W-1:0] value_arr [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        logic              v_q, r_q, m_q, f_q;
        logic [1:0]        k_q;
        logic [DEST_W-1:0] d_q;
        logic [DATA_W-1:0] x_q;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                v_q <= 1'b0;
                r_q <= 1'b0;
                m_q <= 1'b0;
                f_q <= 1'b0;
                k_q <= '0;
                d_q <= '0;
                x_q <= '0;
            end else if (flush) begin
                v_q <= 1'b0;
                r_q <= 1'b0;
            end else if (alloc_ok && tail == TAG_W'(i)) begin
                v_q <= 1'b1;
                r_q <= 1'b0;
                m_q <= 1'b0;
                f_q <= 1'b0;
                k_q <= alloc_kind;
                d_q <= alloc_dest;
            end else if (retire && head == TAG_W'(i)) begin
                v_q <= 1'b0;
                r_q <= 1'b0;
            end else if (cdb_valid && cdb_tag == TAG_W'(i) && v_q && !r_q) begin
                r_q <= 1'b1;
                x_q <= cdb_value;
                m_q <= cdb_mispred;
                f_q <= cdb_fault;
            end
        end

        assign valid_vec[i] = v_q;
        assign ready_vec[i] = r_q;
        assign mp_vec[i]    = m_q;
        assign fault_vec[i] = f_q;
        assign kind_arr[i]  = k_q;
        assign dest_arr[i]  = d_q;
        assign value_arr[i] = x_q;
    end

    assign head_valid = valid_vec[head];
    assign head_ready = ready_vec[head];
    assign head_mp    = mp_vec[head];
    assign head_fault = fault_vec[head];
    assign head_kind  = kind_arr[head];
    assign head_dest  = dest_arr[head];
    assign head_value = value_arr[head];

endmodule

// File: rtl/rob_retire.sv
module rob_retire
    import rob_pkg::*;
#(
    parameter int DEST_W = 32,
    parameter int DATA_W = 32,
    parameter int REG_W  = 5
) (
    input  logic              head_valid,
    input  logic              head_ready,
    input  logic [1:0]        head_kind,
    input  logic [DEST_W-1:0] head_dest,
    input  logic [DATA_W-1:0] head_value,
    input  logic              head_mp,
    input  logic              head_fault,
    output logic              retire,
    output logic              cmt_valid,
    output logic [1:0]        cmt_kind,
    output logic              reg_wr_en,
    output logic [REG_W-1:0]  reg_wr_idx,
    output logic [DATA_W-1:0] reg_wr_data,
    output logic              mem_wr_en,
    output logic [DEST_W-1:0] mem_wr_addr,
    output logic [DATA_W-1:0] mem_wr_data,
    output logic              flush,
    output logic              exc_raise
);

    ret_action_e act;

    // action chosen for the head entry
    always_comb begin
        act = RET_WAIT;
        if (head_valid && head_ready) begin
            if (head_fault) begin
                act = RET_FAULT;
            end else begin
                unique case (op_kind_e'(head_kind))
                    KIND_REG:    act = RET_REG;
                    KIND_STORE:  act = RET_STORE;
                    KIND_BRANCH: act = head_mp ? RET_REDIRECT : RET_BRANCH;
                    default:     act = RET_BRANCH;
                endcase
            end
        end
    end

    // outputs for that action
    always_comb begin
        retire    = 1'b0;
        reg_wr_en = 1'b0;
        mem_wr_en = 1'b0;
        flush     = 1'b0;
        exc_raise = 1'b0;
        unique case (act)
            RET_WAIT:     ;
            RET_REG:      begin retire = 1'b1; reg_wr_en = 1'b1; end
            RET_STORE:    begin retire = 1'b1; mem_wr_en = 1'b1; end
            RET_BRANCH:   retire = 1'b1;
            RET_REDIRECT: begin retire = 1'b1; flush = 1'b1; end
            RET_FAULT:    begin retire = 1'b1; flush = 1'b1; exc_raise = 1'b1; end
            default:      ;
        endcase
    end

    assign cmt_valid   = retire;
    assign cmt_kind    = head_kind;
    assign reg_wr_idx  = head_dest[REG_W-1:0];
    assign reg_wr_data = head_value;
    assign mem_wr_addr = head_dest;
    assign mem_wr_data = head_value;

endmodule

// File: rtl/rob_core.sv
module rob_core #(
    parameter int DEPTH  = 8,
    parameter int DEST_W = 32,
    parameter int DATA_W = 32,
    parameter int REG_W  = 5,
    localparam int TAG_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              iss_valid,
    input  logic [1:0]        iss_kind,
    input  logic [DEST_W-1:0] iss_dest,
    output logic [TAG_W-1:0]  iss_tag,
    output logic              full,
    output logic              empty,
    output logic [CNT_W-1:0]  occ,
    input  logic              cdb_valid,
    input  logic [TAG_W-1:0]  cdb_tag,
    input  logic [DATA_W-1:0] cdb_value,
    input  logic              cdb_mispred,
    input  logic              cdb_fault,
    output logic              cmt_valid,
    output logic [1:0]        cmt_kind,
    output logic              reg_wr_en,
    output logic [REG_W-1:0]  reg_wr_idx,
    output logic [DATA_W-1:0] reg_wr_data,
    output logic              mem_wr_en,
    output logic [DEST_W-1:0] mem_wr_addr,
    output logic [DATA_W-1:0] mem_wr_data,
    output logic              flush,
    output logic              exc_raise
);

    logic              alloc_ok, retire;
    logic [TAG_W-1:0]  head_q, tail_q;
    logic              head_valid, head_ready, head_mp, head_fault;
    logic [1:0]        head_kind;
    logic [DEST_W-1:0] head_dest;
    logic [DATA_W-1:0] head_value;

    rob_ptrs #(.DEPTH(DEPTH)) i_ptrs (
        .clk       (clk),
        .rst_n     (rst_n),
        .alloc_req (iss_valid),
        .retire    (retire),
        .flush     (flush),
        .alloc_ok  (alloc_ok),
        .head_q    (head_q),
        .tail_q    (tail_q),
        .occ_q     (occ),
        .full      (full),
        .empty     (empty)
    );

    rob_slots #(.DEPTH(DEPTH), .DEST_W(DEST_W), .DATA_W(DATA_W)) i_slots (
        .clk         (clk),
        .rst_n       (rst_n),
        .flush       (flush),
        .alloc_ok    (alloc_ok),
        .tail        (tail_q),
        .alloc_kind  (iss_kind),
        .alloc_dest  (iss_dest),
        .retire      (retire),
        .head        (head_q),
        .cdb_valid   (cdb_valid),
        .cdb_tag     (cdb_tag),
        .cdb_value   (cdb_value),
        .cdb_mispred (cdb_mispred),
        .cdb_fault   (cdb_fault),
        .head_valid  (head_valid),
        .head_ready  (head_ready),
        .head_kind   (head_kind),
        .head_dest   (head_dest),
        .head_value  (head_value),
        .head_mp     (head_mp),
        .head_fault  (head_fault)
    );

    rob_retire #(.DEST_W(DEST_W), .DATA_W(DATA_W), .REG_W(REG_W)) i_retire (
        .head_valid  (head_valid),
        .head_ready  (head_ready),
        .head_kind   (head_kind),
        .head_dest   (head_dest),
        .head_value  (head_value),
        .head_mp     (head_mp),
        .head_fault  (head_fault),
        .retire      (retire),
        .cmt_valid   (cmt_valid),
        .cmt_kind    (cmt_kind),
        .reg_wr_en   (reg_wr_en),
        .reg_wr_idx  (reg_wr_idx),
        .reg_wr_data (reg_wr_data),
        .mem_wr_en   (mem_wr_en),
        .mem_wr_addr (mem_wr_addr),
        .mem_wr_data (mem_wr_data),
        .flush       (flush),
        .exc_raise   (exc_raise)
    );

    assign iss_tag = tail_q;

endmodule

// File: rtl/rob_chk.sv
module rob_chk #(
    parameter int DEPTH = 8,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             iss_valid,
    input logic             full,
    input logic             empty,
    input logic [CNT_W-1:0] occ,
    input logic             cmt_valid,
    input logic             reg_wr_en,
    input logic             mem_wr_en,
    input logic             flush,
    input logic             exc_raise
);

    AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(full && empty)); // R3
    AST_OCC_BOUND: assert property (@(posedge clk) disable iff (!rst_n) occ <= CNT_W'(DEPTH)); // R3
    AST_EMPTY_MATCH: assert property (@(posedge clk) disable iff (!rst_n) empty == (occ == '0)); // R3
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        full && iss_valid && !cmt_valid |=> full && occ == $past(occ)); // R2
    AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> empty && occ == '0); // R8
    AST_STORE_AT_COMMIT: assert property (@(posedge clk) disable iff (!rst_n) mem_wr_en |-> cmt_valid); // R7
    AST_WRITE_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(reg_wr_en && mem_wr_en)); // R6
    AST_FAULT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        exc_raise |-> flush && !reg_wr_en && !mem_wr_en); // R9
    AST_OCC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid && !full && cmt_valid && !flush |=> occ == $past(occ)); // R10
    AST_FLUSH_NO_ALLOC: assert property (@(posedge clk) disable iff (!rst_n)
        flush && iss_valid |=> occ == '0); // R11

endmodule

bind rob_core rob_chk #(.DEPTH(DEPTH)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .iss_valid (iss_valid),
    .full      (full),
    .empty     (empty),
    .occ       (occ),
    .cmt_valid (cmt_valid),
    .reg_wr_en (reg_wr_en),
    .mem_wr_en (mem_wr_en),
    .flush     (flush),
    .exc_raise (exc_raise)
);

// File: tb/test_rob_core.sv
module test_rob_core;
    import rob_pkg::*;

    localparam int DEPTH  = 4;
    localparam int DEST_W = 12;
    localparam int DATA_W = 16;
    localparam int REG_W  = 4;
    localparam int TAG_W  = $clog2(DEPTH);
    localparam int CNT_W  = $clog2(DEPTH + 1);

    typedef struct {
        logic [1:0]        kind;
        logic [DEST_W-1:0] dest;
        logic [DATA_W-1:0] val;
        logic              mp;
        logic              flt;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic iss_valid = 1'b0;
    logic [1:0] iss_kind = '0;
    logic [DEST_W-1:0] iss_dest = '0;
    logic [TAG_W-1:0] iss_tag;
    logic full, empty;
    logic [CNT_W-1:0] occ;
    logic cdb_valid = 1'b0;
    logic [TAG_W-1:0] cdb_tag = '0;
    logic [DATA_W-1:0] cdb_value = '0;
    logic cdb_mispred = 1'b0;
    logic cdb_fault = 1'b0;
    logic cmt_valid;
    logic [1:0] cmt_kind;
    logic reg_wr_en, mem_wr_en, flush, exc_raise;
    logic [REG_W-1:0] reg_wr_idx;
    logic [DATA_W-1:0] reg_wr_data, mem_wr_data;
    logic [DEST_W-1:0] mem_wr_addr;

    int total = 0;
    int bad = 0;
    bit done = 0;
    exp_t sb[$];
    logic [DATA_W-1:0] tv [DEPTH];
    logic tm [DEPTH];
    logic tf [DEPTH];

    always #4 clk = ~clk;

    rob_core #(.DEPTH(DEPTH), .DEST_W(DEST_W), .DATA_W(DATA_W), .REG_W(REG_W)) i_rob_core (
        .clk(clk), .rst_n(rst_n),
        .iss_valid(iss_valid), .iss_kind(iss_kind), .iss_dest(iss_dest), .iss_tag(iss_tag),
        .full(full), .empty(empty), .occ(occ),
        .cdb_valid(cdb_valid), .cdb_tag(cdb_tag), .cdb_value(cdb_value),
        .cdb_mispred(cdb_mispred), .cdb_fault(cdb_fault),
        .cmt_valid(cmt_valid), .cmt_kind(cmt_kind),
        .reg_wr_en(reg_wr_en), .reg_wr_idx(reg_wr_idx), .reg_wr_data(reg_wr_data),
        .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
        .flush(flush), .exc_raise(exc_raise)
    );

    task automatic chk(input bit cond, input string req, input string what, input int act, input int expv);
        total++;
        if (!cond) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic issue(input logic [1:0] k, input logic [DEST_W-1:0] d, input logic [DATA_W-1:0] v,
                         input bit mp, input bit flt, input bit accept, output int tag);
        tag = int'(iss_tag);
        iss_valid = 1'b1;
        iss_kind  = k;
        iss_dest  = d;
        if (accept) begin
            tv[tag] = v;
            tm[tag] = mp;
            tf[tag] = flt;
            sb.push_back('{kind: k, dest: d, val: v, mp: mp, flt: flt});
        end
        step();
        iss_valid = 1'b0;
    endtask

    task automatic complete(input int tag);
        cdb_valid   = 1'b1;
        cdb_tag     = TAG_W'(tag);
        cdb_value   = tv[tag];
        cdb_mispred = tm[tag];
        cdb_fault   = tf[tag];
        step();
        cdb_valid   = 1'b0;
    endtask

    // monitor: compares each retirement against the scoreboard
    always @(negedge clk) begin : monitor
        exp_t e;
        bit ex_reg, ex_mem, ex_fl, ok;
        string req;
        if (rst_n && !done && cmt_valid) begin
            if (sb.size() == 0) begin
                total++;
                bad++;
                $display("FAIL R5 unexpected retirement actual=kind%0d expected=none", cmt_kind);
            end else begin
                e = sb.pop_front();
                ex_reg = (e.kind == KIND_REG) && !e.flt;
                ex_mem = (e.kind == KIND_STORE) && !e.flt;
                ex_fl  = e.flt || (e.kind == KIND_BRANCH && e.mp);
                ok = (cmt_kind == e.kind) && (reg_wr_en == ex_reg) && (mem_wr_en == ex_mem)
                     && (flush == ex_fl) && (exc_raise == e.flt)
                     && (!ex_reg || (reg_wr_idx == e.dest[REG_W-1:0] && reg_wr_data == e.val))
                     && (!ex_mem || (mem_wr_addr == e.dest && mem_wr_data == e.val));
                req = e.flt ? "R9" : ex_fl ? "R8" : ex_mem ? "R7" : ex_reg ? "R6" : "R8";
                total++;
                if (!ok) begin
                    bad++;
                    $display("FAIL %s retire actual=k%0d r%0b/%0h/%0h m%0b/%0h/%0h f%0b x%0b expected=k%0d r%0b/%0h/%0h m%0b/%0h/%0h f%0b x%0b",
                             req, cmt_kind, reg_wr_en, reg_wr_idx, reg_wr_data, mem_wr_en, mem_wr_addr,
                             mem_wr_data, flush, exc_raise, e.kind, ex_reg, e.dest[REG_W-1:0], e.val,
                             ex_mem, e.dest, e.val, ex_fl, e.flt);
                end
                if (ex_fl) sb.delete();
            end
        end
    end

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog run did not finish actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        int t0, t1, t2, t3, tx;
        repeat (3) step();
        rst_n = 1'b1;
        step();

        // R1 reset state
        chk(empty == 1'b1, "R1", "empty", int'(empty), 1);
        chk(full == 1'b0 && occ == 0, "R1", "full/occ", int'(occ), 0);
        chk(cmt_valid == 1'b0 && iss_tag == 0, "R1", "cmt_valid/iss_tag", int'(iss_tag), 0);

        // out-of-order completion, in-order retirement
        issue(KIND_REG,   12'h0A3, 16'h1111, 0, 0, 1, t0);
        issue(KIND_STORE, 12'h040, 16'h2222, 0, 0, 1, t1);
        issue(KIND_REG,   12'h0B5, 16'h3333, 0, 0, 1, t2);
        chk(t0 == 0 && t1 == 1 && t2 == 2, "R2", "tags in order", t2, 2);
        chk(occ == 3, "R3", "occ after three issues", int'(occ), 3);
        complete(t2);
        chk(cmt_valid == 1'b0, "R5", "younger ready must not retire", int'(cmt_valid), 0);
        complete(t1);
        chk(mem_wr_en == 1'b0, "R7", "store waits for head", int'(mem_wr_en), 0);
        complete(t0);
        repeat (3) step();
        chk(empty == 1'b1 && occ == 0, "R3", "drained", int'(occ), 0);

        // fill to the top, blocked issue
        issue(KIND_REG,   12'h011, 16'h4001, 0, 0, 1, t3);
        issue(KIND_STORE, 12'h222, 16'h4002, 0, 0, 1, t0);
        issue(KIND_REG,   12'h033, 16'h4003, 0, 0, 1, t1);
        issue(KIND_BRANCH, 12'h000, 16'h0000, 0, 0, 1, t2);
        chk(full == 1'b1 && occ == 4, "R3", "full at DEPTH", int'(occ), 4);
        issue(KIND_REG, 12'h0FF, 16'hDEAD, 0, 0, 0, tx);
        chk(occ == 4 && full == 1'b1, "R2", "issue while full ignored occ", int'(occ), 4);
        chk(iss_tag == 3, "R2", "issue while full ignored tag", int'(iss_tag), 3);
        complete(t0);
        complete(t2);
        complete(t1);
        chk(cmt_valid == 1'b0, "R5", "head not ready", int'(cmt_valid), 0);
        complete(t3);
        repeat (4) step();
        chk(empty == 1'b1, "R3", "drained after full", int'(empty), 1);

        // allocation and retirement in one cycle
        issue(KIND_REG, 12'h0C7, 16'h5151, 0, 0, 1, t0);
        complete(t0);
        issue(KIND_REG, 12'h0D8, 16'h5252, 0, 0, 1, t1);
        chk(occ == 1, "R10", "occ unchanged by alloc+retire", int'(occ), 1);
        complete(t1);
        step();
        chk(empty == 1'b1, "R10", "drained", int'(empty), 1);

        // correctly predicted branch then mispredicted branch
        issue(KIND_BRANCH, 12'h000, 16'h0000, 0, 0, 1, t0);
        issue(KIND_REG, 12'h0E2, 16'h6161, 0, 0, 1, t1);
        complete(t1);
        complete(t0);
        repeat (2) step();
        chk(empty == 1'b1, "R8", "good branch retired", int'(empty), 1);
        issue(KIND_BRANCH, 12'h000, 16'h0000, 1, 0, 1, t0);
        issue(KIND_REG,   12'h0E3, 16'h7171, 0, 0, 1, t1);
        issue(KIND_STORE, 12'h3A0, 16'h7272, 0, 0, 1, t2);
        complete(t1);
        complete(t2);
        complete(t0);
        issue(KIND_REG, 12'h0E4, 16'h7373, 0, 0, 0, tx);
        chk(occ == 0, "R11", "issue during flush ignored", int'(occ), 0);
        chk(empty == 1'b1 && full == 1'b0, "R8", "empty after flush", int'(empty), 1);
        chk(iss_tag == 0, "R8", "tail reset by flush", int'(iss_tag), 0);
        repeat (2) step();
        chk(cmt_valid == 1'b0, "R8", "squashed entries never retire", int'(cmt_valid), 0);

        // stale broadcast to an unallocated slot
        cdb_valid = 1'b1; cdb_tag = '0; cdb_value = 16'hBAD0; cdb_mispred = 0; cdb_fault = 0;
        step();
        cdb_valid = 1'b0;
        issue(KIND_REG, 12'h0F6, 16'h8181, 0, 0, 1, t0);
        repeat (2) step();
        chk(cmt_valid == 1'b0 && occ == 1, "R4", "stale broadcast ignored", int'(cmt_valid), 0);
        complete(t0);
        step();
        chk(empty == 1'b1, "R4", "drained after real result", int'(empty), 1);

        // faulting entry at the head
        issue(KIND_REG,   12'h0A9, 16'h9191, 0, 1, 1, t0);
        issue(KIND_STORE, 12'h155, 16'h9292, 0, 0, 1, t1);
        complete(t1);
        complete(t0);
        chk(exc_raise == 1'b1, "R9", "exception raised", int'(exc_raise), 1);
        step();
        chk(empty == 1'b1 && occ == 0, "R9", "empty after exception", int'(occ), 0);

        // wraparound of the pointers
        for (int i = 0; i < 10; i++) begin
            int tg;
            issue((i % 2) ? KIND_STORE : KIND_REG, DEST_W'(12'h100 + i), DATA_W'(16'hA000 + i), 0, 0, 1, tg);
            chk(tg == (i % DEPTH), "R2", "wrapped tag", tg, i % DEPTH);
            complete(tg);
            step();
        end
        step();
        chk(sb.size() == 0, "R5", "every expected retirement seen", sb.size(), 0);

        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule